// File: doc/BRIEF.md
# Power-Mode and Reset Sequencer

This block owns the power state of a small peripheral device. After any reset it holds the device in a timed reset window. It then runs in the normal state, and from there software can send it to a light sleep state or to a deep, clockless state. It drives the clock enables: one for the fast on-chip RC clock, one flag that says whether the slow 32 kHz clock is running, and one per-block enable that gates the slow clock to each functional block. While the device is not ready, a flag tells the bus slave to refuse its address.

Software writes one 8-bit control byte. The low bits gate individual blocks. Three higher bits request sleep, deep sleep or a soft reset. The request bits act once and are never stored. Wake events come from bus activity, a dedicated wake pin and GPIO hotkey detection, and which of them are honoured depends on the current state. Every wake goes through a timed start-up window, and a one-cycle wake interrupt marks its end. All timing is counted in ticks of the slow clock, delivered as a one-cycle strobe in the system clock domain.

Top module: `lpm_power_sequencer`

## Requirements
- R1: After reset (rst_n low) the block is in the reset-hold state (pwr_state 0), with bus_not_ready and sys_reset high and all block enables low. It moves to the normal state (pwr_state 1) on the edge of the 7th slow tick that follows the release of reset.
- R2: In the normal state, a control write with bits 6..4 clear stores bits 3..0 as gate bits. Block i then has blk_clk_en[i] = NOT gate[i], and fast_clk_en and slow_clk_run are high.
- R3: A control write in the normal state with bit 4 set, and bits 5 and 6 clear, enters sleep (pwr_state 2). In sleep fast_clk_en is low, slow_clk_run is high, and only blocks 0 and 1 may be enabled, each still subject to its gate bit.
- R4: A write with bit 5 set enters deep sleep (pwr_state 3), even when bit 4 is also set. In deep sleep fast_clk_en, slow_clk_run and all blk_clk_en are low.
- R5: A write with bit 6 set takes precedence over bits 5 and 4. It re-enters the reset-hold state for 7 ticks and clears all gate bits.
- R6: In sleep, a one-cycle pulse on bus_activity, wake_pin or hotkey_evt starts the wake window.
- R7: In deep sleep only bus_activity starts the wake window. Pulses on hotkey_evt or wake_pin leave the block in deep sleep.
- R8: The wake window (pwr_state 4) lasts until the edge of the 10th slow tick after it starts. During it bus_not_ready and fast_clk_en are high and all block enables are low. When it ends the state is normal and the gate bits are the ones held before the mode was entered.
- R9: wake_irq pulses high for exactly one cycle, in the first cycle of the normal state after a wake window. It does not pulse after a reset hold.
- R10: Mode and soft-reset requests act once. After returning to the normal state the block stays there until it receives a new request.
- R11: Control writes made outside the normal state are ignored. They change neither the state nor the gate bits.
- R12: Wake inputs have no effect in the normal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | One-cycle strobe per slow-clock period |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte: [3:0] gates, [4] sleep, [5] deep sleep, [6] soft reset |
| bus_activity | input | 1 | Bus traffic seen while asleep |
| wake_pin | input | 1 | Dedicated wake input |
| hotkey_evt | input | 1 | GPIO hotkey event |
| fast_clk_en | output | 1 | RC clock enable |
| slow_clk_run | output | 1 | Slow clock running |
| blk_clk_en | output | NBLK | Per-block slow clock enable |
| sys_reset | output | 1 | Device reset, high during reset hold |
| bus_not_ready | output | 1 | Bus slave must NACK its address |
| wake_irq | output | 1 | One-cycle wake-complete interrupt |
| pwr_state | output | 3 | 0 hold, 1 normal, 2 sleep, 3 deep sleep, 4 waking |

## Verification
The bench uses the default parameters: four blocks, blocks 0 and 1 kept alive in sleep, and a reset hold of 7 ticks and a wake window of 10 ticks. The slow tick strobe fires every 20 system cycles. With these values both timed windows fit in a few hundred cycles, so every exact tick count is measured. Each gate pattern can also be combined with each wake source in both low-power states.

// File: rtl/lpm_pkg.sv
// Shared types and control-byte bit positions of the power sequencer.
package lpm_pkg;
    typedef enum logic [2:0] {
        PS_RST = 3'd0,
        PS_RUN = 3'd1,
        PS_SLP = 3'd2,
        PS_HIB = 3'd3,
        PS_WAK = 3'd4
    } pstate_e;

    localparam int CTL_W     = 8;
    localparam int CTL_SLEEP = 4;
    localparam int CTL_HIB   = 5;
    localparam int CTL_SRST  = 6;
endpackage

// File: rtl/lpm_tick_timer.sv
// Down-counter clocked by slow ticks. It assumes tick is a one-cycle
// strobe. Load wins over a tick in the same cycle. expire pulses on the
// tick that takes the count from 1 to 0.
module lpm_tick_timer #(
    parameter int W    = 4,
    parameter int INIT = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] cnt;

    // Count register: reset to INIT, reload on request, decrement on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= W'(INIT);
        else if (load)               cnt <= load_val;
        else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Expiry decode.
    assign expire = tick && !load && (cnt == W'(1));
endmodule

// File: rtl/lpm_mode_fsm.sv
// Power-state machine. It assumes the control byte layout of lpm_pkg
// and NBLK <= 4. Request bits are acted on and never stored.
module lpm_mode_fsm
    import lpm_pkg::*;
#(
    parameter int NBLK       = 4,
    parameter int RST_TICKS  = 7,
    parameter int WAKE_TICKS = 10,
    parameter int TW         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CTL_W-1:0] cfg_wdata,
    input  logic             bus_act,
    input  logic             wake_pin,
    input  logic             hotkey,
    input  logic             expire,
    output pstate_e          state,
    output logic [NBLK-1:0]  gate,
    output logic             tmr_load,
    output logic [TW-1:0]    tmr_val,
    output logic             wake_irq
);
    pstate_e         nxt;
    logic [NBLK-1:0] gate_nxt;
    logic            irq_nxt;

    // Next-state, gate update and timer load decode.
    always_comb begin
        nxt      = state;
        gate_nxt = gate;
        tmr_load = 1'b0;
        tmr_val  = TW'(WAKE_TICKS);
        irq_nxt  = 1'b0;
        case (state)
            PS_RST: if (expire) nxt = PS_RUN;
            PS_RUN: if (cfg_we) begin
                if (cfg_wdata[CTL_SRST]) begin
                    nxt      = PS_RST;
                    gate_nxt = '0;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RST_TICKS);
                end else begin
                    gate_nxt = cfg_wdata[NBLK-1:0];
                    if (cfg_wdata[CTL_HIB])        nxt = PS_HIB;
                    else if (cfg_wdata[CTL_SLEEP]) nxt = PS_SLP;
                end
            end
            PS_SLP: if (bus_act || wake_pin || hotkey) begin
                nxt      = PS_WAK;
                tmr_load = 1'b1;
            end
            PS_HIB: if (bus_act) begin
                nxt      = PS_WAK;
                tmr_load = 1'b1;
            end
            PS_WAK: if (expire) begin
                nxt     = PS_RUN;
                irq_nxt = 1'b1;
            end
            default: nxt = PS_RST;
        endcase
    end

    // State, gate and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PS_RST;
            gate     <= '0;
            wake_irq <= 1'b0;
        end else begin
            state    <= nxt;
            gate     <= gate_nxt;
            wake_irq <= irq_nxt;
        end
    end

    a_r4_hib_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_RUN && cfg_we && cfg_wdata[CTL_HIB] && !cfg_wdata[CTL_SRST])
        |=> state == PS_HIB);
    a_r7_hib_bus_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_HIB && !bus_act) |=> state == PS_HIB);
    a_r9_irq_after_wake: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> (state == PS_RUN && $past(state) == PS_WAK));
    a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |=> !wake_irq);
    a_r11_gate_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PS_RUN) |=> $stable(gate));
endmodule

// File: rtl/lpm_clk_gate.sv
// Maps the power state and gate bits onto the clock enables. KEEP marks
// the blocks that stay clocked in sleep. clk and rst_n serve the checks.
module lpm_clk_gate
    import lpm_pkg::*;
#(
    parameter int              NBLK = 4,
    parameter logic [NBLK-1:0] KEEP = 4'b0011
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pstate_e         state,
    input  logic [NBLK-1:0] gate,
    output logic            fast_en,
    output logic            slow_run,
    output logic [NBLK-1:0] blk_en
);
    // RC clock runs in normal state, reset hold and wake window.
    assign fast_en  = (state == PS_RUN) || (state == PS_RST) || (state == PS_WAK);
    // Slow clock stops only in deep sleep.
    assign slow_run = (state != PS_HIB);

    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        // Per-block enable: open in normal state, in sleep only for kept blocks.
        always_comb begin
            if (state == PS_RUN)                blk_en[i] = !gate[i];
            else if (state == PS_SLP && KEEP[i]) blk_en[i] = !gate[i];
            else                                 blk_en[i] = 1'b0;
        end
    end

    a_r3_sleep_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_SLP) |-> ((blk_en & ~KEEP) == '0 && !fast_en));
endmodule

// File: rtl/lpm_power_sequencer.sv
// Top of the power-mode and reset sequencer. It assumes tick_32k is a
// one-cycle strobe in the clk domain and that wake inputs are synchronous.
module lpm_power_sequencer
    import lpm_pkg::*;
#(
    parameter int              NBLK       = 4,
    parameter logic [NBLK-1:0] KEEP       = 4'b0011,
    parameter int              RST_TICKS  = 7,
    parameter int              WAKE_TICKS = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_32k,
    input  logic            cfg_we,
    input  logic [7:0]      cfg_wdata,
    input  logic            bus_activity,
    input  logic            wake_pin,
    input  logic            hotkey_evt,
    output logic            fast_clk_en,
    output logic            slow_clk_run,
    output logic [NBLK-1:0] blk_clk_en,
    output logic            sys_reset,
    output logic            bus_not_ready,
    output logic            wake_irq,
    output logic [2:0]      pwr_state
);
    localparam int MAXT = (RST_TICKS > WAKE_TICKS) ? RST_TICKS : WAKE_TICKS;
    localparam int TW   = $clog2(MAXT + 1);

    pstate_e         state;
    logic [NBLK-1:0] gate;
    logic            tmr_load, expire;
    logic [TW-1:0]   tmr_val;

    lpm_tick_timer #(.W(TW), .INIT(RST_TICKS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .tick(tick_32k), .expire(expire)
    );

    lpm_mode_fsm #(.NBLK(NBLK), .RST_TICKS(RST_TICKS),
                   .WAKE_TICKS(WAKE_TICKS), .TW(TW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .bus_act(bus_activity), .wake_pin(wake_pin), .hotkey(hotkey_evt),
        .expire(expire), .state(state), .gate(gate), .tmr_load(tmr_load),
        .tmr_val(tmr_val), .wake_irq(wake_irq)
    );

    lpm_clk_gate #(.NBLK(NBLK), .KEEP(KEEP)) u_cg (
        .clk(clk), .rst_n(rst_n), .state(state), .gate(gate),
        .fast_en(fast_clk_en), .slow_run(slow_clk_run), .blk_en(blk_clk_en)
    );

    assign sys_reset     = (state == PS_RST);
    assign bus_not_ready = (state == PS_RST) || (state == PS_WAK);
    assign pwr_state     = state;

    a_r1_hold_blocks_off: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset |-> (blk_clk_en == '0 && bus_not_ready));
endmodule

// File: tb/tb_lpm_power_sequencer.sv
module tb_lpm_power_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       bus_activity = 1'b0, wake_pin = 1'b0, hotkey_evt = 1'b0;
    logic       fast_clk_en, slow_clk_run, sys_reset, bus_not_ready, wake_irq;
    logic [3:0] blk_clk_en;
    logic [2:0] pwr_state;

    int tests = 0, fails = 0;
    int tcount = 0;
    int snap;
    bit done = 0;

    lpm_power_sequencer dut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .bus_activity(bus_activity), .wake_pin(wake_pin),
        .hotkey_evt(hotkey_evt), .fast_clk_en(fast_clk_en),
        .slow_clk_run(slow_clk_run), .blk_clk_en(blk_clk_en),
        .sys_reset(sys_reset), .bus_not_ready(bus_not_ready),
        .wake_irq(wake_irq), .pwr_state(pwr_state)
    );

    always #5 clk = ~clk;

    always @(posedge clk) if (tick_32k) tcount <= tcount + 1;

    initial begin : tickgen
        forever begin
            repeat (19) @(negedge clk);
            tick_32k = 1'b1;
            @(negedge clk);
            tick_32k = 1'b0;
        end
    end

    // Stimulus table: write byte, wake source (0 bus, 1 pin, 2 hotkey),
    // expected mode state, expected block enables in mode, wakes or not.
    localparam logic [7:0] V_WD [7] = '{8'h10, 8'h14, 8'h11, 8'h20, 8'h30, 8'h23, 8'h1F};
    localparam logic [2:0] V_SRC[7] = '{3'b100, 3'b010, 3'b001, 3'b100, 3'b010, 3'b001, 3'b100};
    localparam logic [2:0] V_ST [7] = '{3'd2, 3'd2, 3'd2, 3'd3, 3'd3, 3'd3, 3'd2};
    localparam logic [3:0] V_EN [7] = '{4'b0011, 4'b0011, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0000};
    localparam bit         V_WK [7] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = 8'h00;
    endtask

    task automatic pulse(input logic [2:0] s);
        bus_activity = s[0]; wake_pin = s[1]; hotkey_evt = s[2];
        @(negedge clk);
        bus_activity = 1'b0; wake_pin = 1'b0; hotkey_evt = 1'b0;
    endtask

    task automatic wait_state(input logic [2:0] s);
        for (int k = 0; k < 2000 && pwr_state != s; k++) @(negedge clk);
    endtask

    task automatic wait_irq();
        for (int k = 0; k < 2000 && !wake_irq; k++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 state in reset", pwr_state, 0);
        chk("R1 not_ready in reset", bus_not_ready, 1);
        chk("R1 sys_reset in reset", sys_reset, 1);
        chk("R1 block enables off", blk_clk_en, 0);
        rst_n = 1'b1;
        snap = tcount;
        wait_state(3'd1);
        chk("R1 hold length in ticks", tcount - snap, 7);
        chk("R9 no irq after hold", wake_irq, 0);
        chk("R1 not_ready cleared", bus_not_ready, 0);

        // R2: gate bits in the normal state
        wr(8'h05);
        chk("R2 gated enables", blk_clk_en, 4'b1010);
        chk("R2 fast clock on", fast_clk_en, 1);
        wr(8'h00);
        chk("R2 all enables", blk_clk_en, 4'b1111);

        // R12: wake inputs in the normal state
        pulse(3'b111);
        @(negedge clk);
        chk("R12 state unchanged", pwr_state, 1);
        chk("R12 no irq", wake_irq, 0);

        // Table walk over modes and wake sources
        for (int i = 0; i < 7; i++) begin
            wr(V_WD[i]);
            chk(V_ST[i] == 3 ? "R4 mode state" : "R3 mode state", pwr_state, V_ST[i]);
            chk(V_ST[i] == 3 ? "R4 enables" : "R3 enables", blk_clk_en, V_EN[i]);
            chk(V_ST[i] == 3 ? "R4 fast off" : "R3 fast off", fast_clk_en, 0);
            chk(V_ST[i] == 3 ? "R4 slow run" : "R3 slow run", slow_clk_run, V_ST[i] != 3);
            pulse(V_SRC[i]);
            snap = tcount;
            if (V_WK[i]) begin
                chk(V_ST[i] == 3 ? "R7 bus wakes" : "R6 source wakes", pwr_state, 4);
                chk("R8 not_ready in window", bus_not_ready, 1);
                chk("R8 fast on in window", fast_clk_en, 1);
                chk("R8 enables off in window", blk_clk_en, 0);
                wait_irq();
                chk("R8 window length in ticks", tcount - snap, 10);
                chk("R9 irq in normal state", pwr_state, 1);
                chk("R8 gates kept", blk_clk_en, 4'(~V_WD[i][3:0]));
                @(negedge clk);
                chk("R9 irq one cycle", wake_irq, 0);
            end else begin
                repeat (60) @(negedge clk);
                chk("R7 ignored source", pwr_state, V_ST[i]);
                chk("R7 no irq", wake_irq, 0);
                pulse(3'b001);
                wait_irq();
                chk("R7 bus recovers", pwr_state, 1);
            end
            repeat (50) @(negedge clk);
            chk("R10 request acted once", pwr_state, 1);
        end

        // R11: writes outside the normal state
        wr(8'h13);
        chk("R3 sleep entered", pwr_state, 2);
        wr(8'h20);
        wr(8'h0C);
        chk("R11 write ignored in sleep", pwr_state, 2);
        chk("R11 sleep enables kept", blk_clk_en, 4'b0000);
        pulse(3'b010);
        wr(8'h40);
        chk("R11 write ignored in window", pwr_state, 4);
        wait_irq();
        chk("R11 gates unchanged", blk_clk_en, 4'b1100);

        // R5: soft reset has priority and clears gates
        wr(8'h7A);
        snap = tcount;
        chk("R5 back in hold", pwr_state, 0);
        chk("R5 sys_reset", sys_reset, 1);
        chk("R5 not_ready", bus_not_ready, 1);
        wait_state(3'd1);
        chk("R5 hold length in ticks", tcount - snap, 7);
        chk("R5 gates cleared", blk_clk_en, 4'b1111);
        repeat (100) @(negedge clk);
        chk("R10 soft reset acted once", pwr_state, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule